// File: doc/BRIEF.md
# UV Sample Sequencer with Threshold Interrupt

This block decides when the UV converter takes a sample and tells the host that a fresh value is waiting. One sequencer serves three operating states. In continuous operation it asks for a sample at a fixed rate. In single-shot operation one write request produces exactly one sample. When neither is selected the block is powered down and asks for nothing. Each returned 8-bit value is held in an output register, and a data-available flag is raised. Reading the output register drops that flag again.

Every new value is compared against a programmable threshold, which yields an above event and a below event. Each event has its own enable, and a master enable gates the whole event circuit. The events can either follow the latest sample or stay latched until the host reads the source register. A 2-bit selector routes one event kind to a single interrupt pin: data-ready, above, below, or either of the two. The pin has a programmable polarity and can drive as push-pull or as open-drain. A reboot request keeps a busy flag set for one sample-rate period while trim values are reloaded, and the flag clears by itself at the end.

Top module: `uvi_sample_irq`

## Requirements
- R1: With `cont_en`=1, `sample_req` is a one-cycle pulse that repeats every RATE_DIV clock cycles.
- R2: With `cont_en`=0, a `oneshot_wr` pulse raises `sample_req` for one cycle and `oneshot_busy` in the cycle that follows the write. A `oneshot_wr` that arrives while `oneshot_busy` is set causes no further request.
- R3: `oneshot_busy` clears on the same clock edge at which `conv_valid` loads the new value into `uv_out`.
- R4: With `cont_en`=0 and no single-shot pending, `sample_req` stays 0. A `oneshot_wr` given while `cont_en`=1 is ignored, and `oneshot_busy` stays 0.
- R5: `conv_valid` loads `conv_data` into `uv_out` and sets `data_avail`. `rd_out` clears `data_avail`, but a `conv_valid` in the same cycle keeps it set.
- R6: A sample above `thresh` (strictly greater) gives a high event, and a sample below it (strictly less) gives a low event. A sample equal to the threshold gives neither. Each event needs its own enable (`hi_en`, `lo_en`), and with `irq_en`=0 all source flags read 0.
- R7: `src_flags` bit 0 is the high event, bit 1 is the low event, and bit 2 (interrupt active) is the OR of the two.
- R8: With `latch_en`=1, event flags accumulate across samples and clear only when `rd_src` is pulsed. With `latch_en`=0, the flags reflect only the most recent sample, and `rd_src` has no effect.
- R9: `route_sel` selects the asserted condition: 00 is `data_avail`, 01 is the high flag, 10 is the low flag, and 11 is high OR low.
- R10: `irq_o` equals the asserted condition when `irq_act_low`=0, and its inverse when `irq_act_low`=1.
- R11: With `irq_od`=0, `irq_oe` is always 1. With `irq_od`=1, `irq_oe` is 1 only while the condition is asserted.
- R12: A `boot_wr` pulse sets `boot_busy` for exactly RATE_DIV cycles. `trim_reload` pulses once, in the last of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cont_en | input | 1 | Continuous sampling select |
| oneshot_wr | input | 1 | Pulse: single-shot request written |
| boot_wr | input | 1 | Pulse: trim reload request written |
| irq_en | input | 1 | Master enable for threshold events |
| hi_en | input | 1 | High event enable |
| lo_en | input | 1 | Low event enable |
| latch_en | input | 1 | Latch events until source read |
| route_sel | input | 2 | Interrupt pin source select |
| irq_act_low | input | 1 | Pin polarity, 1 = active low |
| irq_od | input | 1 | Pin drive, 1 = open-drain |
| thresh | input | DATA_W | Event threshold |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | DATA_W | Converter result |
| rd_out | input | 1 | Output register read strobe |
| rd_src | input | 1 | Source register read strobe |
| sample_req | output | 1 | Pulse: start a conversion |
| oneshot_busy | output | 1 | Single-shot bit readback |
| boot_busy | output | 1 | Reboot bit readback |
| trim_reload | output | 1 | Pulse: trim reload completes |
| uv_out | output | DATA_W | Last sample value |
| data_avail | output | 1 | New value not yet read |
| src_flags | output | 3 | {active, low, high} event flags |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
The hardest state to reach is a latched event flag that has to survive a later sample which does not cross the threshold, and then vanish on a source read. The stimulus sets up latching and sends an above-threshold value. It then sends a value exactly equal to the threshold, followed by a below-threshold value, and checks that the two flags accumulate before pulsing the source read. A second hard case is a read strobe that lands in the same cycle as a new converter result, which the bench drives on a single clock edge.

// File: rtl/uvi_pkg.sv
// Package: types shared by the UV sample sequencer and its interrupt logic.
// Assumes: 2-bit route encoding is fixed by the host-visible register field.
package uvi_pkg;
    typedef enum logic [1:0] {
        ROUTE_DRDY   = 2'b00,
        ROUTE_HIGH   = 2'b01,
        ROUTE_LOW    = 2'b10,
        ROUTE_EITHER = 2'b11
    } route_e;

    typedef struct packed {
        logic active;
        logic low;
        logic high;
    } src_t;
endpackage

// File: rtl/uvi_period_timer.sv
// Period timer: while en is high, counts clock cycles and pulses tick once
// every PERIOD cycles; the count returns to zero whenever en is low.
// Assumes: PERIOD >= 2.
module uvi_period_timer #(
    parameter int PERIOD = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Advance or clear the period count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uvi_sequencer.sv
// Sequencer: issues conversion requests in continuous or single-shot
// operation, powers down when neither is selected, and times the trim
// reboot over one sample-rate period.
// Assumes: oneshot_wr and boot_wr are single-cycle write strobes.
module uvi_sequencer #(
    parameter int RATE_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cont_en,
    input  logic oneshot_wr,
    input  logic boot_wr,
    input  logic conv_valid,
    output logic sample_req,
    output logic oneshot_busy,
    output logic boot_busy,
    output logic trim_reload
);
    logic rate_tick;
    logic boot_tick;
    logic os_start;

    uvi_period_timer #(.PERIOD(RATE_DIV)) rate_tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cont_en),
        .tick (rate_tick)
    );

    uvi_period_timer #(.PERIOD(RATE_DIV)) boot_tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (boot_busy),
        .tick (boot_tick)
    );

    assign os_start    = oneshot_wr && !cont_en && !oneshot_busy;
    assign trim_reload = boot_busy && boot_tick;

    // Request pulse and single-shot busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_req   <= 1'b0;
            oneshot_busy <= 1'b0;
        end else begin
            sample_req <= (cont_en && rate_tick) || os_start;
            if (os_start) begin
                oneshot_busy <= 1'b1;
            end else if (conv_valid) begin
                oneshot_busy <= 1'b0;
            end
        end
    end

    // Reboot busy flag, self-clearing after one period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_busy <= 1'b0;
        end else if (boot_wr) begin
            boot_busy <= 1'b1;
        end else if (boot_tick) begin
            boot_busy <= 1'b0;
        end
    end

    // R4
    power_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> (oneshot_busy || $past(cont_en)));
    // R3
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_busy && conv_valid && !oneshot_wr) |=> !oneshot_busy);
    // R12
    boot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_busy) |-> $past(boot_wr));
    // R12
    boot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_reload && !boot_wr) |=> !boot_busy);
endmodule

// File: rtl/uvi_event_unit.sv
// Event unit: holds the last sample and its data-available flag, compares
// each sample against the threshold and keeps live or latched event flags.
// Assumes: rd_out and rd_src are single-cycle read strobes.
module uvi_event_unit
    import uvi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [DATA_W-1:0] thresh,
    input  logic              irq_en,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic              latch_en,
    input  logic              rd_out,
    input  logic              rd_src,
    output logic [DATA_W-1:0] uv_out,
    output logic              data_avail,
    output src_t              src
);
    logic hi_q, lo_q;
    logic new_hi, new_lo;

    assign new_hi = conv_valid && irq_en && hi_en && (conv_data > thresh);
    assign new_lo = conv_valid && irq_en && lo_en && (conv_data < thresh);

    // Output register and data-available flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uv_out     <= '0;
            data_avail <= 1'b0;
        end else if (conv_valid) begin
            uv_out     <= conv_data;
            data_avail <= 1'b1;
        end else if (rd_out) begin
            data_avail <= 1'b0;
        end
    end

    // Event flags, latched or following the latest sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !irq_en) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else if (latch_en) begin
            hi_q <= (hi_q && !rd_src) || new_hi;
            lo_q <= (lo_q && !rd_src) || new_lo;
        end else if (conv_valid) begin
            hi_q <= new_hi;
            lo_q <= new_lo;
        end
    end

    assign src = '{active: hi_q || lo_q, low: lo_q, high: hi_q};

    // R5
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> (data_avail && uv_out == $past(conv_data)));
    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out && !conv_valid) |=> !data_avail);
    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && irq_en && src.high && !rd_src) |=> src.high);
    // R6
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> (src.high == 1'b0 && src.low == 1'b0));
endmodule

// File: rtl/uvi_irq_drive.sv
// Interrupt pin driver: selects the routed condition, applies polarity and
// chooses push-pull or open-drain drive enable.
// Assumes: pad logic outside drives the pin from irq_o when irq_oe is high.
module uvi_irq_drive
    import uvi_pkg::*;
(
    input  route_e route,
    input  logic   act_low,
    input  logic   open_drain,
    input  logic   data_avail,
    input  src_t   src,
    output logic   irq_o,
    output logic   irq_oe
);
    logic asserted;

    // Pick the condition routed to the pin.
    always_comb begin
        unique case (route)
            ROUTE_DRDY:   asserted = data_avail;
            ROUTE_HIGH:   asserted = src.high;
            ROUTE_LOW:    asserted = src.low;
            ROUTE_EITHER: asserted = src.high || src.low;
            default:      asserted = 1'b0;
        endcase
    end

    assign irq_o  = asserted ^ act_low;
    assign irq_oe = open_drain ? asserted : 1'b1;
endmodule

// File: rtl/uvi_sample_irq.sv
// Top: UV sample sequencer with threshold events and interrupt pin.
// Assumes: all strobes are synchronous to clk and one cycle long.
module uvi_sample_irq
    import uvi_pkg::*;
#(
    parameter int RATE_DIV = 32768,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cont_en,
    input  logic              oneshot_wr,
    input  logic              boot_wr,
    input  logic              irq_en,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic              latch_en,
    input  logic [1:0]        route_sel,
    input  logic              irq_act_low,
    input  logic              irq_od,
    input  logic [DATA_W-1:0] thresh,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_out,
    input  logic              rd_src,
    output logic              sample_req,
    output logic              oneshot_busy,
    output logic              boot_busy,
    output logic              trim_reload,
    output logic [DATA_W-1:0] uv_out,
    output logic              data_avail,
    output logic [2:0]        src_flags,
    output logic              irq_o,
    output logic              irq_oe
);
    src_t src;

    uvi_sequencer #(.RATE_DIV(RATE_DIV)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cont_en     (cont_en),
        .oneshot_wr  (oneshot_wr),
        .boot_wr     (boot_wr),
        .conv_valid  (conv_valid),
        .sample_req  (sample_req),
        .oneshot_busy(oneshot_busy),
        .boot_busy   (boot_busy),
        .trim_reload (trim_reload)
    );

    uvi_event_unit #(.DATA_W(DATA_W)) evt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_valid(conv_valid),
        .conv_data (conv_data),
        .thresh    (thresh),
        .irq_en    (irq_en),
        .hi_en     (hi_en),
        .lo_en     (lo_en),
        .latch_en  (latch_en),
        .rd_out    (rd_out),
        .rd_src    (rd_src),
        .uv_out    (uv_out),
        .data_avail(data_avail),
        .src       (src)
    );

    uvi_irq_drive drv_i (
        .route     (route_e'(route_sel)),
        .act_low   (irq_act_low),
        .open_drain(irq_od),
        .data_avail(data_avail),
        .src       (src),
        .irq_o     (irq_o),
        .irq_oe    (irq_oe)
    );

    assign src_flags = src;

    // R9
    drdy_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel == 2'b00 && !irq_od) |-> (irq_oe && irq_o == (data_avail ^ irq_act_low)));
    // R7
    active_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_flags[2] == (src_flags[1] || src_flags[0]));
endmodule

// File: tb/uvi_sample_irq_tb.sv
// Directed bench for uvi_sample_irq: one task per scenario.
module uvi_sample_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RATE       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cont_en = 0, oneshot_wr = 0, boot_wr = 0;
    logic       irq_en = 0, hi_en = 0, lo_en = 0, latch_en = 0;
    logic [1:0] route_sel = 2'b00;
    logic       irq_act_low = 0, irq_od = 0;
    logic [7:0] thresh = 8'h00;
    logic       conv_valid = 0;
    logic [7:0] conv_data = 8'h00;
    logic       rd_out = 0, rd_src = 0;
    logic       sample_req, oneshot_busy, boot_busy, trim_reload;
    logic [7:0] uv_out;
    logic       data_avail;
    logic [2:0] src_flags;
    logic       irq_o, irq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uvi_sample_irq #(.RATE_DIV(RATE), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .oneshot_wr(oneshot_wr),
        .boot_wr(boot_wr), .irq_en(irq_en), .hi_en(hi_en), .lo_en(lo_en),
        .latch_en(latch_en), .route_sel(route_sel), .irq_act_low(irq_act_low),
        .irq_od(irq_od), .thresh(thresh), .conv_valid(conv_valid),
        .conv_data(conv_data), .rd_out(rd_out), .rd_src(rd_src),
        .sample_req(sample_req), .oneshot_busy(oneshot_busy),
        .boot_busy(boot_busy), .trim_reload(trim_reload), .uv_out(uv_out),
        .data_avail(data_avail), .src_flags(src_flags), .irq_o(irq_o),
        .irq_oe(irq_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_sample(input logic [7:0] d);
        @(negedge clk); conv_valid = 1; conv_data = d;
        @(negedge clk); conv_valid = 0;
    endtask

    task automatic t_reset;
        check("R5 reset data_avail", data_avail, 0);
        check("R5 reset uv_out", uv_out, 0);
        check("R7 reset src_flags", src_flags, 0);
        check("R4 reset sample_req", sample_req, 0);
        check("R11 reset irq_oe", irq_oe, 1);
        check("R9 reset irq_o", irq_o, 0);
    endtask

    task automatic t_oneshot;
        int n = 0;
        cont_en = 0;
        @(negedge clk); oneshot_wr = 1;
        @(negedge clk); oneshot_wr = 0;
        check("R2 request after write", sample_req, 1);
        check("R2 busy after write", oneshot_busy, 1);
        oneshot_wr = 1;
        @(negedge clk); oneshot_wr = 0;
        check("R2 single pulse, repeat write ignored", sample_req, 0);
        check("R2 busy held", oneshot_busy, 1);
        send_sample(8'h55);
        check("R3 busy cleared", oneshot_busy, 0);
        check("R3 value loaded", uv_out, 8'h55);
        for (int i = 0; i < 3*RATE; i++) begin
            @(negedge clk); if (sample_req) n++;
        end
        check("R4 power-down no requests", n, 0);
    endtask

    task automatic t_continuous;
        int n = 0;
        int w = 0;
        @(negedge clk); cont_en = 1; oneshot_wr = 1;
        @(negedge clk); oneshot_wr = 0;
        check("R4 one-shot ignored in continuous", oneshot_busy, 0);
        while (!sample_req && w < 4*RATE) begin @(negedge clk); w++; end
        check("R1 first request seen", sample_req, 1);
        do begin @(negedge clk); n++; end while (!sample_req && n < 4*RATE);
        check("R1 request period", n, RATE);
        @(negedge clk);
        check("R1 request one cycle", sample_req, 0);
        cont_en = 0;
        n = 0;
        for (int i = 0; i < 3*RATE; i++) begin
            @(negedge clk); if (sample_req) n++;
        end
        check("R4 no requests after stop", n, 0);
    endtask

    task automatic t_data_flag;
        send_sample(8'h21);
        check("R5 flag set", data_avail, 1);
        check("R5 value", uv_out, 8'h21);
        @(negedge clk); rd_out = 1;
        @(negedge clk); rd_out = 0;
        check("R5 cleared by read", data_avail, 0);
        @(negedge clk); rd_out = 1; conv_valid = 1; conv_data = 8'h9a;
        @(negedge clk); rd_out = 0; conv_valid = 0;
        check("R5 new sample wins over read", data_avail, 1);
        check("R5 collision value", uv_out, 8'h9a);
        @(negedge clk); rd_out = 1;
        @(negedge clk); rd_out = 0;
    endtask

    task automatic t_compare;
        thresh = 8'h40; irq_en = 1; hi_en = 1; lo_en = 1; latch_en = 0;
        send_sample(8'h41);
        check("R6 R7 above -> high+active", src_flags, 3'b101);
        send_sample(8'h3f);
        check("R6 R7 below -> low+active", src_flags, 3'b110);
        send_sample(8'h40);
        check("R6 equal -> none", src_flags, 3'b000);
        hi_en = 0;
        send_sample(8'hf0);
        check("R6 high disabled", src_flags, 3'b000);
        hi_en = 1; irq_en = 0;
        send_sample(8'hf0);
        check("R6 master off", src_flags, 3'b000);
        irq_en = 1;
        send_sample(8'h50);
        @(negedge clk); rd_src = 1;
        @(negedge clk); rd_src = 0;
        check("R8 live flags ignore source read", src_flags, 3'b101);
    endtask

    task automatic t_latch;
        latch_en = 1;
        @(negedge clk); rd_src = 1;
        @(negedge clk); rd_src = 0;
        check("R8 cleared before test", src_flags, 3'b000);
        send_sample(8'h50);
        check("R8 latched high", src_flags, 3'b101);
        send_sample(8'h40);
        check("R8 high held over quiet sample", src_flags, 3'b101);
        send_sample(8'h10);
        check("R8 accumulate low", src_flags, 3'b111);
        @(negedge clk); rd_src = 1;
        @(negedge clk); rd_src = 0;
        check("R8 cleared by source read", src_flags, 3'b000);
        latch_en = 0;
    endtask

    task automatic t_route;
        irq_act_low = 0; irq_od = 0; route_sel = 2'b00;
        send_sample(8'h50);
        check("R9 route drdy asserted", irq_o, 1);
        @(negedge clk); rd_out = 1;
        @(negedge clk); rd_out = 0;
        check("R9 route drdy after read", irq_o, 0);
        route_sel = 2'b01; #1;
        check("R9 route high", irq_o, 1);
        route_sel = 2'b10; #1;
        check("R9 route low", irq_o, 0);
        route_sel = 2'b11; #1;
        check("R9 route either", irq_o, 1);
        check("R11 push-pull drives", irq_oe, 1);
        irq_act_low = 1; route_sel = 2'b01; #1;
        check("R10 active low asserted", irq_o, 0);
        route_sel = 2'b10; #1;
        check("R10 active low idle", irq_o, 1);
        irq_od = 1; #1;
        check("R11 open-drain released", irq_oe, 0);
        route_sel = 2'b01; #1;
        check("R11 open-drain drives", irq_oe, 1);
        check("R10 R11 open-drain level", irq_o, 0);
        irq_act_low = 0; irq_od = 0; route_sel = 2'b00;
    endtask

    task automatic t_boot;
        int busy_n = 0;
        int rl_n = 0;
        @(negedge clk); boot_wr = 1;
        @(negedge clk); boot_wr = 0;
        check("R12 busy set", boot_busy, 1);
        for (int i = 0; i < 3*RATE; i++) begin
            if (boot_busy) busy_n++;
            if (trim_reload) rl_n++;
            @(negedge clk);
        end
        check("R12 busy length", busy_n, RATE);
        check("R12 reload pulses", rl_n, 1);
        check("R12 busy self-cleared", boot_busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_continuous();
        t_data_flag();
        t_compare();
        t_latch();
        t_route();
        t_boot();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule